// File: doc/BRIEF.md
# Pipelined Word-Sliced Conditional Subtractor

This block performs the closing correction of a Montgomery modular product. It takes a wide value `u`, an extra carry bit that sits just above the top word of `u`, and a modulus `n`. It returns `u - n` when the full value (carry bit included) is at least `n`, and returns `u` unchanged when it is not. The result is the reduced product, held to the width of the modulus.

A single compare-and-subtract across the whole operand would form one long borrow chain, and that chain would set the clock rate. This design cuts the operand into equal word slices. Each slice works out its own word difference and its borrow in one cycle, then passes the borrow through a register to the next slice up. The words of `u` and `n` that are still waiting, and the difference words already formed, travel down the pipeline with it, so every word of an operand arrives at the output stage together.

At the output stage, the final borrow and the carry bit decide whether the difference or the original value is returned. A new operand can enter on every cycle. Each result comes out after a fixed latency: one cycle per slice plus one cycle for the output register. The word width and the number of slices are parameters.

Top module: `wsplit_csub`

## Requirements
- R1: In the cycle after reset, `out_valid` is 0 and `out_res` is all zeros.
- R2: Every accepted input (`in_valid` high at a clock edge) produces exactly one result, and `out_valid` rises exactly WORDS+1 clock edges after the edge that accepted the input.
- R3: When `in_top` is 0 and `in_u >= in_n` (unsigned), `out_res` equals `in_u - in_n`.
- R4: When `in_top` is 0 and `in_u < in_n` (unsigned), `out_res` equals `in_u` unchanged.
- R5: When `in_top` is 0 and `in_u == in_n`, `out_res` is zero.
- R6: When `in_top` is 1, the subtraction is always chosen: `out_res` equals `(in_u - in_n) mod 2^(WORD_W*WORDS)`, even when `in_u < in_n`.
- R7: A borrow from a slice reaches every higher slice. Example: with `in_u = 2^96`, `in_n = 1` and 32-bit words, the result is `2^96 - 1`. Example: when the upper words are equal and only the lowest word of `u` is smaller, the value is kept.
- R8: Inputs offered on consecutive cycles each give their own correct result, in order, on consecutive cycles.
- R9: While `out_valid` is 0, `out_res` keeps its last value.
- R10: The same structure works with 2-bit words and four slices. Example: `u = 00001010b`, `n = 11100000b` gives the output `00001010b`. Example: `u = 11100101b`, `n = 11100000b` gives `00000101b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set is present this cycle |
| in_u | input | WORD_W*WORDS | Value to reduce; word k occupies bits [k*WORD_W +: WORD_W] |
| in_top | input | 1 | Carry bit sitting just above the top word of `in_u` |
| in_n | input | WORD_W*WORDS | Modulus, with the same word layout as `in_u` |
| out_valid | output | 1 | `out_res` holds a new result this cycle |
| out_res | output | WORD_W*WORDS | Reduced value |

## Verification
Two things can happen in the same cycle. While one operand's borrow is still moving up through the slices, the next operand is being accepted into slice zero. The bench provokes this by streaming back-to-back operands that alternate between the keep decision and the subtract decision, and one of them has the carry bit set. Each result must match a reference computed at full width in the bench, it must appear exactly WORDS+1 cycles after its input, and the results must stay in order. This shows that no borrow or selection leaks from one operand into its neighbour.

// File: rtl/wsplit_csub_pkg.sv
package wsplit_csub_pkg;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_WORDS  = 4;

  // Outcome of the final decision stage
  typedef enum logic {
    PICK_KEEP = 1'b0,
    PICK_DIFF = 1'b1
  } pick_e;
endpackage

// File: rtl/wsplit_word_sub.sv
// One word slice: a - b - bin, with borrow out.
module wsplit_word_sub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bin,
  output logic [W-1:0] d,
  output logic         bout
);
  logic [W:0] full;

  always_comb begin
    full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
  end

  assign d    = full[W-1:0];
  assign bout = full[W];
endmodule

// File: rtl/wsplit_stage.sv
// Pipeline stage IDX: subtracts word IDX and registers all in-flight state.
module wsplit_stage #(
  parameter int W   = 32,
  parameter int N   = 4,
  parameter int IDX = 0,
  localparam int TW = W * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic          top_i,
  input  logic          b_i,
  input  logic [TW-1:0] u_i,
  input  logic [TW-1:0] n_i,
  input  logic [TW-1:0] d_i,
  output logic          v_o,
  output logic          top_o,
  output logic          b_o,
  output logic [TW-1:0] u_o,
  output logic [TW-1:0] n_o,
  output logic [TW-1:0] d_o
);
  logic [W-1:0]  a_w, b_w, diff_w;
  logic          bout_w;
  logic [TW-1:0] d_next;

  assign a_w = u_i[IDX*W +: W];
  assign b_w = n_i[IDX*W +: W];

  wsplit_word_sub #(.W(W)) u_sub (
    .a    (a_w),
    .b    (b_w),
    .bin  (b_i),
    .d    (diff_w),
    .bout (bout_w)
  );

  always_comb begin
    d_next = d_i;
    d_next[IDX*W +: W] = diff_w;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  // Data path carries no reset; qualified by v_o
  always_ff @(posedge clk) begin
    top_o <= top_i;
    b_o   <= bout_w;
    u_o   <= u_i;
    n_o   <= n_i;
    d_o   <= d_next;
  end

  // R7: the registered word difference recombines with the operands
  a_r7_word_diff: assert property (@(posedge clk) disable iff (rst)
    v_o |-> ((d_o[IDX*W +: W] + $past(b_w) + {{(W-1){1'b0}}, $past(b_i)}) == $past(a_w)));

  // R7: the borrow flag is set exactly when the word underflows
  a_r7_borrow_flag: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (b_o == ({1'b0, $past(a_w)} < ({1'b0, $past(b_w)} + {{W{1'b0}}, $past(b_i)}))));
endmodule

// File: rtl/wsplit_pick.sv
// Final stage: choose difference or original value, register the output.
module wsplit_pick
  import wsplit_csub_pkg::*;
#(
  parameter int W   = 32,
  parameter int N   = 4,
  localparam int TW = W * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic          top_i,
  input  logic          b_i,
  input  logic [TW-1:0] u_i,
  input  logic [TW-1:0] n_i,
  input  logic [TW-1:0] d_i,
  output logic          v_o,
  output logic [TW-1:0] res_o
);
  pick_e pick;

  always_comb begin
    pick = (top_i || !b_i) ? PICK_DIFF : PICK_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o   <= 1'b0;
      res_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) res_o <= (pick == PICK_DIFF) ? d_i : u_i;
    end
  end

  // R3: full-width compare shows u >= n, so the difference must be output
  a_r3_sub_when_above: assert property (@(posedge clk) disable iff (rst)
    (v_o && !$past(top_i) && ($past(u_i) >= $past(n_i))) |-> (res_o == $past(u_i) - $past(n_i)));

  // R4: full-width compare shows u < n, so u must pass through
  a_r4_keep_when_below: assert property (@(posedge clk) disable iff (rst)
    (v_o && !$past(top_i) && ($past(u_i) < $past(n_i))) |-> (res_o == $past(u_i)));

  // R6: the carry bit forces the subtraction
  a_r6_top_forces: assert property (@(posedge clk) disable iff (rst)
    (v_o && $past(top_i)) |-> (res_o == $past(u_i) - $past(n_i)));

  // R9: the result holds when no new result is present
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !v_o |-> $stable(res_o));
endmodule

// File: rtl/wsplit_csub.sv
module wsplit_csub
  import wsplit_csub_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int WORDS  = DEF_WORDS,
  localparam int TW    = WORD_W * WORDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [TW-1:0] in_u,
  input  logic          in_top,
  input  logic [TW-1:0] in_n,
  output logic          out_valid,
  output logic [TW-1:0] out_res
);
  logic [WORDS:0] st_v, st_t, st_b;
  logic [TW-1:0]  st_u [0:WORDS];
  logic [TW-1:0]  st_n [0:WORDS];
  logic [TW-1:0]  st_d [0:WORDS];

  assign st_v[0] = in_valid;
  assign st_t[0] = in_top;
  assign st_b[0] = 1'b0;
  assign st_u[0] = in_u;
  assign st_n[0] = in_n;
  assign st_d[0] = '0;

  for (genvar k = 0; k < WORDS; k++) begin : g_stage
    wsplit_stage #(.W(WORD_W), .N(WORDS), .IDX(k)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .v_i   (st_v[k]),
      .top_i (st_t[k]),
      .b_i   (st_b[k]),
      .u_i   (st_u[k]),
      .n_i   (st_n[k]),
      .d_i   (st_d[k]),
      .v_o   (st_v[k+1]),
      .top_o (st_t[k+1]),
      .b_o   (st_b[k+1]),
      .u_o   (st_u[k+1]),
      .n_o   (st_n[k+1]),
      .d_o   (st_d[k+1])
    );
  end

  wsplit_pick #(.W(WORD_W), .N(WORDS)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .v_i   (st_v[WORDS]),
    .top_i (st_t[WORDS]),
    .b_i   (st_b[WORDS]),
    .u_i   (st_u[WORDS]),
    .n_i   (st_n[WORDS]),
    .d_i   (st_d[WORDS]),
    .v_o   (out_valid),
    .res_o (out_res)
  );

  // R1: a reset cycle leaves the output idle and cleared
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && (out_res == '0)));
endmodule

// File: tb/wsplit_csub_tb.sv
module wsplit_csub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 32;
  localparam int N   = 4;
  localparam int TW  = W * N;
  localparam int LAT = N + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_u = '0;
  logic          in_top = 1'b0;
  logic [TW-1:0] in_n = '0;
  logic          out_valid;
  logic [TW-1:0] out_res;

  logic       s_in_valid = 1'b0;
  logic [7:0] s_in_u = '0;
  logic       s_in_top = 1'b0;
  logic [7:0] s_in_n = '0;
  logic       s_out_valid;
  logic [7:0] s_out_res;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [TW-1:0] exp_res [0:63];
  int            exp_cyc [0:63];
  string         exp_tag [0:63];
  int wr = 0;
  int rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wsplit_csub #(.WORD_W(W), .WORDS(N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_u(in_u), .in_top(in_top),
    .in_n(in_n), .out_valid(out_valid), .out_res(out_res)
  );

  wsplit_csub #(.WORD_W(2), .WORDS(4)) u_dut_small (
    .clk(clk), .rst(rst), .in_valid(s_in_valid), .in_u(s_in_u), .in_top(s_in_top),
    .in_n(s_in_n), .out_valid(s_out_valid), .out_res(s_out_res)
  );

  task automatic check(input bit ok, input string req, input logic [TW-1:0] act,
                       input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] ref_res(input logic [TW-1:0] u, input logic top,
                                           input logic [TW-1:0] n);
    if (top || (u >= n)) return u - n;
    return u;
  endfunction

  // Scoreboard: compare every result with the queued reference and latency
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd < wr) begin
        check(out_res == exp_res[rd % 64], exp_tag[rd % 64], out_res, exp_res[rd % 64]);
        check((cyc - exp_cyc[rd % 64]) == LAT, "R2 latency",
              TW'(cyc - exp_cyc[rd % 64]), TW'(LAT));
        rd++;
      end else begin
        check(1'b0, "R2 spurious result", out_res, '0);
      end
    end
  end

  task automatic push(input logic [TW-1:0] u, input logic top, input logic [TW-1:0] n,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_u = u;
    in_top = top;
    in_n = n;
    exp_res[wr % 64] = ref_res(u, top, n);
    exp_cyc[wr % 64] = cyc;
    exp_tag[wr % 64] = tag;
    wr++;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    @(negedge clk);
    in_valid = 1'b0;
    while (rd < wr && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    check(rd == wr, tag, TW'(rd), TW'(wr));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", TW'(out_valid), '0);
    check(out_res == '0, "R1 out_res after reset", out_res, '0);
  endtask

  task automatic t_basic();
    push(128'h9000_0000_0000_0001_0000_0000_0000_0005, 1'b0,
         128'h8000_0000_0000_0000_0000_0000_0000_0003, "R3 u above n");
    push(128'h1234_5678_9abc_def0_1111_2222_3333_4444, 1'b0,
         128'h1234_5678_9abc_def0_1111_2222_3333_4445, "R4 u just below n");
    push(128'hdd54_fd6a_a41a_0dbc_b755_0b28_4862_b7a5, 1'b0,
         128'hdd54_fd6a_a41a_0dbc_b755_0b28_4862_b7a5, "R5 u equal n");
    push(128'h0000_0001_ffff_ffff_0000_0000_0000_0000, 1'b0,
         128'h0000_0001_0000_0000_ffff_ffff_ffff_ffff, "R3 mixed words");
    drain("R3 basic all results returned");
  endtask

  task automatic t_top();
    push(128'h5, 1'b1, 128'ha, "R6 carry set with u below n");
    push(128'hffff_0000_0000_0000_0000_0000_0000_0000, 1'b1,
         128'h8000_0000_0000_0000_0000_0000_0000_0001, "R6 carry set with u above n");
    drain("R6 all results returned");
  endtask

  task automatic t_ripple();
    push(128'h0000_0001_0000_0000_0000_0000_0000_0000, 1'b0, 128'h1, "R7 borrow through three slices");
    push(128'h0000_0005_0000_0000_0000_0000_0000_0000, 1'b0,
         128'h0000_0005_0000_0000_0000_0000_0000_0001, "R7 borrow makes u below n");
    drain("R7 all results returned");
  endtask

  task automatic t_stream();
    logic [TW-1:0] base = 128'h8000_0000_0000_0000_0000_0000_0000_0000;
    for (int i = 0; i < 10; i++) begin
      if (i == 5)
        push(base - 128'd3, 1'b1, base, "R8 stream carry item");
      else if (i % 2 == 1)
        push(base + TW'(i) * 128'h1_0000_0001, 1'b0, base, "R8 stream subtract item");
      else
        push(base - TW'(i + 1) * 128'h1_0000_0000_0000_0001, 1'b0, base, "R8 stream keep item");
    end
    drain("R8 stream all results returned");
  endtask

  task automatic t_hold();
    logic [TW-1:0] held;
    @(negedge clk);
    held = out_res;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9 no result while idle", TW'(out_valid), '0);
      check(out_res == held, "R9 result held", out_res, held);
    end
  endtask

  task automatic t_small(input logic [7:0] u, input logic [7:0] n, input logic [7:0] exp);
    int guard = 0;
    @(negedge clk);
    s_in_valid = 1'b1;
    s_in_u = u;
    s_in_top = 1'b0;
    s_in_n = n;
    @(negedge clk);
    s_in_valid = 1'b0;
    while (!s_out_valid && guard < 10) begin
      @(negedge clk);
      guard++;
    end
    check(s_out_valid == 1'b1, "R10 small result appears", TW'(s_out_valid), TW'(1));
    check(s_out_res == exp, "R10 small result value", TW'(s_out_res), TW'(exp));
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_top();
    t_ripple();
    t_stream();
    t_hold();
    t_small(8'b0000_1010, 8'b1110_0000, 8'b0000_1010);
    t_small(8'b1110_0101, 8'b1110_0000, 8'b0000_0101);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule